// File: doc/BRIEF.md
# Battery Pack Protection Fault Controller

This block decides, once per clock, whether the charge-path switch and the discharge-path switch of a lithium battery pack may conduct. It takes the latched per-cell voltage summaries from a cell poller, two raw over-current comparator bits, charger-present and load-present indications, an active-low test hold and a one-millisecond tick. From these it keeps four latched fault flags, each with its own release condition, and drives the two switch enables, a sleep flag and an active-low charge-fault output.

Each over-current comparator bit must stay high for a continuous run of ticks before it counts as a fault. The charge-side run is long, the discharge-side run is short. Any low cycle on a comparator starts its run again. An undervoltage summary forces the low-power sleep state, and only a charger can end that state.

Top module: `pack_guard`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `test_n` low, `chg_en`=1, `dsg_en`=1, `sleep`=0 and `fault_n`=1. All latched faults and qualification runs are cleared.
- R2: A charge over-current fault latches on the tick that completes `CHG_OC_TICKS` ticks (default 1000) seen with `chg_oc_cmp` high in every cycle. A single low cycle restarts the count from zero.
- R3: A discharge over-current fault latches on the tick that completes more than `DSG_OC_TICKS` ticks (default 3, so the 4th) seen with `dsg_oc_cmp` high in every cycle. A single low cycle restarts the count from zero.
- R4: A charge over-current fault forces `chg_en` to 0 and leaves `dsg_en` unchanged. It is released in a cycle where `charger_on`=0 or `load_on`=1.
- R5: A discharge over-current fault forces `dsg_en` to 0 and leaves `chg_en` unchanged. It is released in a cycle where `load_on`=0 or `charger_on`=1.
- R6: `ov_flag`=1 latches an overvoltage fault that forces `chg_en` to 0. The fault is released in a cycle with `ov_flag`=0 and `hyst_ok`=1, meaning every cell is below the hysteresis level.
- R7: `uv_flag`=1 latches sleep. In sleep, `sleep`=1 and `dsg_en`=0. Sleep ends only in a cycle with `charger_on`=1 and `uv_flag`=0. Load and over-current activity have no effect on it.
- R8: `fault_n` is 0 exactly while an overvoltage fault or a charge over-current fault is latched, and 1 otherwise.
- R9: When overvoltage and undervoltage faults occur together, sleep persists until a charger appears. With a charger present, each new `uv_flag` re-enters sleep, and the charger clears it again.
- R10: Every output reflects the inputs sampled at one rising clock edge, and it is visible immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_n | input | 1 | Active-low test hold; clears all logic while low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| ov_flag | input | 1 | Some cell above the overvoltage limit (from poller) |
| hyst_ok | input | 1 | Every cell below the overvoltage hysteresis level |
| uv_flag | input | 1 | Some cell below the undervoltage limit (from poller) |
| chg_oc_cmp | input | 1 | Charge current comparator output |
| dsg_oc_cmp | input | 1 | Discharge current comparator output |
| charger_on | input | 1 | Charger attached |
| load_on | input | 1 | Load attached |
| chg_en | output | 1 | Charge-path switch enable |
| dsg_en | output | 1 | Discharge-path switch enable |
| sleep | output | 1 | Low-power sleep state |
| fault_n | output | 1 | Active-low charge-side fault |

## Verification
Every fault set and every release acts through a single register. An input sampled at a rising edge therefore shows on the outputs right after that edge. A qualification run shows up exactly on the edge that samples its completing tick. The bench drives inputs on falling edges. A behavioural model advances on each rising edge from the same input values, and all four outputs are compared with it on the next falling edge, so each result is checked in the cycle it is due. Directed checks at the end of each phase confirm the settled state of the switches and flags. These checks also cover the one-tick-short cases of both current runs.

// File: rtl/pack_guard.sv
module pack_guard #(
  parameter int CHG_OC_TICKS = 1000,
  parameter int DSG_OC_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_n,
  input  logic tick_ms,
  input  logic ov_flag,
  input  logic hyst_ok,
  input  logic uv_flag,
  input  logic chg_oc_cmp,
  input  logic dsg_oc_cmp,
  input  logic charger_on,
  input  logic load_on,
  output logic chg_en,
  output logic dsg_en,
  output logic sleep,
  output logic fault_n
);
  localparam int DSG_LIM = DSG_OC_TICKS + 1;
  localparam int CW = $clog2(CHG_OC_TICKS + 1);
  localparam int DW = $clog2(DSG_LIM + 1);

  logic [CW-1:0] c_run;
  logic [DW-1:0] d_run;
  logic c_oc, d_oc, ov_f, sleep_f;

  wire c_done = tick_ms && (c_run == CW'(CHG_OC_TICKS - 1));
  wire d_done = tick_ms && (d_run == DW'(DSG_LIM - 1));
  wire c_rel  = !charger_on || load_on;
  wire d_rel  = !load_on || charger_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_run <= '0; d_run <= '0;
      c_oc <= 1'b0; d_oc <= 1'b0; ov_f <= 1'b0; sleep_f <= 1'b0;
    end else if (!test_n) begin
      c_run <= '0; d_run <= '0;
      c_oc <= 1'b0; d_oc <= 1'b0; ov_f <= 1'b0; sleep_f <= 1'b0;
    end else begin
      if (c_oc) begin
        c_run <= '0;
        if (c_rel) c_oc <= 1'b0;
      end else if (!chg_oc_cmp) begin
        c_run <= '0;
      end else if (c_done) begin
        c_run <= '0;
        c_oc  <= 1'b1;
      end else if (tick_ms) begin
        c_run <= c_run + 1'b1;
      end

      if (d_oc) begin
        d_run <= '0;
        if (d_rel) d_oc <= 1'b0;
      end else if (!dsg_oc_cmp) begin
        d_run <= '0;
      end else if (d_done) begin
        d_run <= '0;
        d_oc  <= 1'b1;
      end else if (tick_ms) begin
        d_run <= d_run + 1'b1;
      end

      if (ov_flag) ov_f <= 1'b1;
      else if (hyst_ok) ov_f <= 1'b0;

      if (uv_flag) sleep_f <= 1'b1;
      else if (charger_on) sleep_f <= 1'b0;
    end
  end

  assign chg_en  = !(c_oc || ov_f);
  assign dsg_en  = !(d_oc || sleep_f);
  assign sleep   = sleep_f;
  assign fault_n = !(c_oc || ov_f);
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic test_n,
  input logic ov_flag,
  input logic uv_flag,
  input logic chg_oc_cmp,
  input logic dsg_oc_cmp,
  input logic charger_on,
  input logic chg_en,
  input logic dsg_en,
  input logic sleep,
  input logic fault_n
);
  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !test_n |=> (chg_en && dsg_en && !sleep && fault_n)); // R1
  AST_CHG_NO_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && !chg_oc_cmp && !ov_flag) |=> chg_en); // R2
  AST_DSG_NO_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dsg_en && !dsg_oc_cmp && !uv_flag) |=> dsg_en); // R3
  AST_OV_CUTS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && test_n) |=> !chg_en); // R6
  AST_SLEEP_NEEDS_CHARGER: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !charger_on && test_n) |=> sleep); // R7
  AST_SLEEP_CUTS_DSG: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dsg_en); // R7
  AST_FAULT_CUTS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !chg_en); // R8
endmodule

bind pack_guard pack_guard_chk u_chk (.*);

// File: tb/sim_pack_guard.sv
`timescale 1ns/1ps
module sim_pack_guard;
  localparam int CT = 1000;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, test_n = 1'b1, tick_ms = 1'b0;
  logic ov_flag = 1'b0, hyst_ok = 1'b0, uv_flag = 1'b0;
  logic chg_oc_cmp = 1'b0, dsg_oc_cmp = 1'b0, charger_on = 1'b0, load_on = 1'b0;
  logic chg_en, dsg_en, sleep, fault_n;

  always #4 clk = ~clk;

  pack_guard u0 (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  string cur = "R1";

  int mc = 0, md = 0;
  bit m_c = 0, m_d = 0, m_ov = 0, m_sl = 0;

  always @(posedge clk) begin
    if (!rst_n || !test_n) begin
      mc = 0; md = 0; m_c = 0; m_d = 0; m_ov = 0; m_sl = 0;
    end else begin
      if (m_c) begin mc = 0; if (!charger_on || load_on) m_c = 0; end
      else if (!chg_oc_cmp) mc = 0;
      else if (tick_ms) begin mc++; if (mc >= CT) begin m_c = 1; mc = 0; end end
      if (m_d) begin md = 0; if (!load_on || charger_on) m_d = 0; end
      else if (!dsg_oc_cmp) md = 0;
      else if (tick_ms) begin md++; if (md > DT) begin m_d = 1; md = 0; end end
      if (ov_flag) m_ov = 1; else if (hyst_ok) m_ov = 0;
      if (uv_flag) m_sl = 1; else if (charger_on) m_sl = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    chk(cur, "chg_en", chg_en, !(m_c || m_ov));
    chk(cur, "dsg_en", dsg_en, !(m_d || m_sl));
    chk(cur, "sleep", sleep, m_sl);
    chk(cur, "fault_n", fault_n, !(m_c || m_ov));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
      cyc++;
      tick_ms = (cyc % 4 == 0);
    end
  endtask

  initial begin
    #100000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset chg_en", chg_en, 1'b1);
    chk("R1", "reset dsg_en", dsg_en, 1'b1);
    chk("R1", "reset fault_n", fault_n, 1'b1);
    rst_n = 1'b1;
    run(8);

    // R2: run broken after 500 ticks, then a full run
    cur = "R2"; charger_on = 1'b1; chg_oc_cmp = 1'b1;
    run(4 * 500);
    chg_oc_cmp = 1'b0; run(1); chg_oc_cmp = 1'b1;
    run(4 * (CT - 1));
    chk("R2", "one tick short", chg_en, 1'b1);
    run(12);
    chk("R2", "latched", chg_en, 1'b0);
    chk("R4", "dsg untouched", dsg_en, 1'b1);
    chk("R8", "fault_n on charge oc", fault_n, 1'b0);

    // R4: release by load
    cur = "R4"; chg_oc_cmp = 1'b0; run(4);
    chk("R4", "held with charger", chg_en, 1'b0);
    load_on = 1'b1; run(2);
    chk("R4", "released", chg_en, 1'b1);

    // R3: discharge run broken then complete
    cur = "R3"; charger_on = 1'b0; dsg_oc_cmp = 1'b1;
    run(4 * DT);
    chk("R3", "three ticks", dsg_en, 1'b1);
    dsg_oc_cmp = 1'b0; run(1); dsg_oc_cmp = 1'b1;
    run(4 * DT + 4);
    chk("R3", "latched", dsg_en, 1'b0);
    chk("R5", "chg untouched", chg_en, 1'b1);

    // R5: release by removing load
    cur = "R5"; dsg_oc_cmp = 1'b0; run(4);
    chk("R5", "held with load", dsg_en, 1'b0);
    load_on = 1'b0; run(2);
    chk("R5", "released", dsg_en, 1'b1);

    // R6 / R8: overvoltage and hysteresis
    cur = "R6"; ov_flag = 1'b1; run(1); ov_flag = 1'b0; run(6);
    chk("R6", "ov holds", chg_en, 1'b0);
    chk("R8", "fault_n on ov", fault_n, 1'b0);
    hyst_ok = 1'b1; run(2);
    chk("R6", "ov released", chg_en, 1'b1);
    chk("R8", "fault_n clear", fault_n, 1'b1);
    hyst_ok = 1'b0;

    // R7: sleep ignores load and current activity
    cur = "R7"; uv_flag = 1'b1; run(1); uv_flag = 1'b0;
    load_on = 1'b1; dsg_oc_cmp = 1'b1; run(40);
    dsg_oc_cmp = 1'b0; load_on = 1'b0; run(4);
    chk("R7", "still asleep", sleep, 1'b1);
    chk("R7", "dsg off", dsg_en, 1'b0);
    charger_on = 1'b1; run(2);
    chk("R7", "woken by charger", sleep, 1'b0);
    charger_on = 1'b0;

    // R9: combined faults
    cur = "R9"; ov_flag = 1'b1; uv_flag = 1'b1; run(1);
    ov_flag = 1'b0; uv_flag = 1'b0; run(10);
    chk("R9", "sleep kept", sleep, 1'b1);
    charger_on = 1'b1; run(2);
    chk("R9", "woken", sleep, 1'b0);
    uv_flag = 1'b1; run(1); uv_flag = 1'b0;
    chk("R9", "re-entered", sleep, 1'b1);
    run(1);
    chk("R9", "cycled out", sleep, 1'b0);
    charger_on = 1'b0;

    // R1: test hold clears faults
    cur = "R1"; ov_flag = 1'b1; uv_flag = 1'b1; run(1);
    ov_flag = 1'b0; uv_flag = 1'b0; test_n = 1'b0; run(3);
    chk("R1", "test chg_en", chg_en, 1'b1);
    chk("R1", "test dsg_en", dsg_en, 1'b1);
    chk("R1", "test sleep", sleep, 1'b0);
    test_n = 1'b1;

    // R10: outputs settle one edge after sampling (every-cycle compare)
    cur = "R10"; ov_flag = 1'b1; run(1);
    chk("R10", "one edge latency", chg_en, 1'b0);
    ov_flag = 1'b0; hyst_ok = 1'b1; run(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule